// File: doc/BRIEF.md
# FSK Carrier Detect and Data Qualifier

This block sits behind an FSK demodulator in a caller-identification receive path. It estimates the amplitude of the band-limited line samples with a leaky average of their magnitude and compares that estimate with a programmable threshold. Timers measured in bit periods turn the comparison into a debounced, active-low carrier-present flag. The flag falls only after the level has stayed high for a whole acquisition window. It rises only after the level has stayed low for a whole release window, so a short fade does not end a message.

The same bit-rate tick samples the raw demodulated bit stream. A validator watches for a long enough run of alternating 0/1 bits, followed by a run of mark (1) bits, while the carrier is qualified. Until that sequence has been seen, the cooked data output is held at mark. After it has been seen, the cooked output follows the raw bit stream, so the firmware UART gets the later mark bits and the message but never the preamble. When the carrier flag is released, the validator returns to its hunting state and needs a fresh preamble before data flows again. Lowering the enable input clears everything.

Top module: `fsk_carrier_qualifier`

## Requirements
- R1: While `rst` is high, and from the first clock edge after `en` goes low, `carrier_n` is 1. `cooked_data` is 1 in every cycle in which `en` is 0.
- R2: The level estimate is a leaky average of the sample magnitude, with a leak of 1/2^LEAK_SHIFT per clock. The level counts as present only when the estimate is strictly greater than `level_thresh`. A steady magnitude equal to the threshold never qualifies a carrier.
- R3: `carrier_n` falls only after ACQ_BITS consecutive bit ticks at which the level was present, and never earlier.
- R4: Once qualified, `carrier_n` rises after REL_BITS consecutive bit ticks at which the level was absent.
- R5: A level dropout that covers fewer than REL_BITS ticks leaves `carrier_n` low, and the release count starts again from zero.
- R6: A bit tick occurs once every CLK_DIV clocks while enabled. `raw_bit` is sampled exactly once per tick, so a stream that changes every CLK_DIV clocks is seen bit for bit.
- R7: `cooked_data` stays 1 until validation passes. Validation needs three things while the carrier is qualified: an alternating run of at least PRE_MIN bits, a repeated 1 to end it, and then a mark run of MARK_MIN ones that counts the last 1 of the alternating run.
- R8: After validation passes, `cooked_data` equals `raw_bit` until `carrier_n` rises. After that, `cooked_data` stays 1 until a new preamble and mark run have been seen.
- R9: An alternating run shorter than PRE_MIN bits never lets data through, however many marks follow it.
- R10: A 0 that arrives before the mark run reaches MARK_MIN sends the validator back to hunting, and `cooked_data` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; when low, all state is cleared and the outputs idle high |
| sample_in | input | SAMPLE_W | Signed band-limited line sample, one per clock |
| level_thresh | input | SAMPLE_W | Unsigned detection threshold for the level estimate |
| raw_bit | input | 1 | Raw demodulated bit, 1 = mark |
| carrier_n | output | 1 | Active-low carrier-qualified flag |
| cooked_data | output | 1 | Raw bits after validation, otherwise held at 1 |

## Verification
The bench targets the strict threshold comparison with a steady magnitude exactly at the threshold: a design that uses greater-or-equal would qualify the carrier there. It measures acquisition and release against windows one bit period short of and past the nominal count. A timer that counts one tick too few, or does not restart after a brief fade, moves the flag outside those windows. On the data side it sends a short preamble, a mark run broken by a space, and a message after re-acquisition with no new preamble. A validator that does not saturate or reset properly leaks the preamble, or leaks data in one of those cases. Randomized amplitudes and message bits check that passed data matches the raw stream bit for bit, starting at the exact bit where validation completes.

// File: rtl/fskq_pkg.sv
package fskq_pkg;

    localparam int CNT_W = 8;   // validator counters; PRE_MIN and MARK_MIN must stay below 2**CNT_W

    typedef enum logic [1:0] {
        VAL_HUNT  = 2'd0,
        VAL_MARKS = 2'd1,
        VAL_PASS  = 2'd2
    } val_state_e;

    typedef struct packed {
        val_state_e         state;
        logic [CNT_W-1:0]   run;     // length of the current alternating run
        logic [CNT_W-1:0]   marks;   // length of the current mark run
        logic               prev;    // bit sampled at the previous tick
    } val_ctx_t;

    localparam val_ctx_t VAL_CTX_IDLE = '{state: VAL_HUNT, run: '0, marks: '0, prev: 1'b1};

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] cap);
        return (v < cap) ? v + 1'b1 : cap;
    endfunction

endpackage

// File: rtl/fskq_level.sv
module fskq_level #(
    parameter int SAMPLE_W   = 12,
    parameter int LEAK_SHIFT = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic        [SAMPLE_W-1:0] level_thresh,
    output logic                       above
);
    localparam int ACC_W = SAMPLE_W + LEAK_SHIFT;

    logic [SAMPLE_W-1:0] mag;
    logic [ACC_W-1:0]    acc_q, acc_d;
    logic [SAMPLE_W-1:0] level;

    always_comb begin
        mag   = sample_in[SAMPLE_W-1] ? (~sample_in + 1'b1) : sample_in;
        acc_d = acc_q - (acc_q >> LEAK_SHIFT) + {{LEAK_SHIFT{1'b0}}, mag};
        level = acc_q[ACC_W-1:LEAK_SHIFT];
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc_q <= '0;
            above <= 1'b0;
        end else begin
            acc_q <= acc_d;
            above <= (level > level_thresh);
        end
    end
endmodule

// File: rtl/fskq_tick.sv
module fskq_tick #(
    parameter int CLK_DIV = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(CLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || tick) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/fskq_carrier.sv
module fskq_carrier #(
    parameter int ACQ_BITS = 17,
    parameter int REL_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic above,
    output logic qualified
);
    localparam int TMAX = (ACQ_BITS > REL_BITS) ? ACQ_BITS : REL_BITS;
    localparam int CW   = $clog2(TMAX + 1);

    logic [CW-1:0] cnt_q;
    logic          counting;   // level in the state that moves the flag
    logic [CW-1:0] limit;

    always_comb begin
        counting = qualified ? !above : above;
        limit    = qualified ? CW'(REL_BITS - 1) : CW'(ACQ_BITS - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q     <= '0;
            qualified <= 1'b0;
        end else if (!counting) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == limit) begin
                cnt_q     <= '0;
                qualified <= !qualified;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fskq_validator.sv
module fskq_validator
    import fskq_pkg::*;
#(
    parameter int PRE_MIN  = 10,
    parameter int MARK_MIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic qualified,
    input  logic raw_bit,
    output logic pass
);
    localparam logic [CNT_W-1:0] PRE_CAP  = CNT_W'(PRE_MIN);
    localparam logic [CNT_W-1:0] MARK_CAP = CNT_W'(MARK_MIN);

    val_ctx_t ctx_q, ctx_d;

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.prev = raw_bit;
        unique case (ctx_q.state)
            VAL_HUNT: begin
                if (raw_bit != ctx_q.prev) begin
                    ctx_d.run = sat_inc(ctx_q.run, PRE_CAP);
                end else if (raw_bit && ctx_q.run >= PRE_CAP) begin
                    ctx_d.state = (MARK_MIN <= 2) ? VAL_PASS : VAL_MARKS;
                    ctx_d.marks = CNT_W'(2);
                end else begin
                    ctx_d.run = CNT_W'(1);
                end
            end
            VAL_MARKS: begin
                if (!raw_bit) begin
                    ctx_d.state = VAL_HUNT;
                    ctx_d.run   = CNT_W'(2);
                    ctx_d.marks = '0;
                end else if (ctx_q.marks + 1'b1 >= MARK_CAP) begin
                    ctx_d.state = VAL_PASS;
                end else begin
                    ctx_d.marks = ctx_q.marks + 1'b1;
                end
            end
            default: ctx_d.state = VAL_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en || !qualified) ctx_q <= VAL_CTX_IDLE;
        else if (tick)                ctx_q <= ctx_d;
    end

    assign pass = (ctx_q.state == VAL_PASS);
endmodule

// File: rtl/fsk_carrier_qualifier.sv
module fsk_carrier_qualifier #(
    parameter int SAMPLE_W   = 12,
    parameter int LEAK_SHIFT = 3,
    parameter int CLK_DIV    = 3000,
    parameter int ACQ_BITS   = 17,
    parameter int REL_BITS   = 10,
    parameter int PRE_MIN    = 10,
    parameter int MARK_MIN   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic        [SAMPLE_W-1:0] level_thresh,
    input  logic                       raw_bit,
    output logic                       carrier_n,
    output logic                       cooked_data
);
    logic lvl_above;
    logic bit_tick;
    logic carrier_ok;
    logic val_pass;

    fskq_level #(.SAMPLE_W(SAMPLE_W), .LEAK_SHIFT(LEAK_SHIFT)) u_level (
        .clk(clk), .rst(rst), .en(en),
        .sample_in(sample_in), .level_thresh(level_thresh), .above(lvl_above)
    );

    fskq_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst(rst), .en(en), .tick(bit_tick)
    );

    fskq_carrier #(.ACQ_BITS(ACQ_BITS), .REL_BITS(REL_BITS)) u_carrier (
        .clk(clk), .rst(rst), .en(en), .tick(bit_tick),
        .above(lvl_above), .qualified(carrier_ok)
    );

    fskq_validator #(.PRE_MIN(PRE_MIN), .MARK_MIN(MARK_MIN)) u_validator (
        .clk(clk), .rst(rst), .en(en), .tick(bit_tick),
        .qualified(carrier_ok), .raw_bit(raw_bit), .pass(val_pass)
    );

    assign carrier_n   = !carrier_ok;
    assign cooked_data = (en && carrier_ok && val_pass) ? raw_bit : 1'b1;
endmodule

// File: rtl/fskq_checker.sv
module fskq_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic above,
    input logic tick,
    input logic qualified,
    input logic pass,
    input logic raw_bit,
    input logic carrier_n,
    input logic cooked_data
);
    AST_DISABLED_DATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |-> cooked_data);                                              // R1
    AST_DISABLED_CARRIER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> carrier_n);                                                // R1
    AST_ACQ_ON_LEVEL_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(carrier_n) |-> ($past(above) && $past(tick)));               // R3
    AST_REL_ON_QUIET_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(carrier_n) |-> (!$past(en) || (!$past(above) && $past(tick)))); // R4
    AST_PASS_ON_MARK_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(pass) |-> ($past(raw_bit) && $past(tick) && $past(qualified))); // R7
    AST_NO_DATA_WITHOUT_CARRIER: assert property (@(posedge clk) disable iff (rst)
        carrier_n |-> cooked_data);                                        // R8
    AST_PASS_CLEARS_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
        (pass && !qualified) |=> !pass);                                   // R8
endmodule

bind fsk_carrier_qualifier fskq_checker u_fskq_checker (
    .clk(clk), .rst(rst), .en(en), .above(lvl_above), .tick(bit_tick),
    .qualified(carrier_ok), .pass(val_pass), .raw_bit(raw_bit),
    .carrier_n(carrier_n), .cooked_data(cooked_data)
);

// File: tb/test_fsk_carrier_qualifier.sv
module test_fsk_carrier_qualifier;
    localparam int CLK_PERIOD = 10;
    localparam int SW   = 12;
    localparam int DIV  = 8;
    localparam int ACQ  = 17;
    localparam int REL  = 10;
    localparam int PMIN = 10;
    localparam int MMIN = 4;
    localparam int THR  = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic signed [SW-1:0] sample_in = '0;
    logic [SW-1:0] level_thresh = SW'(THR);
    logic raw_bit = 1'b1;
    logic carrier_n, cooked_data;

    int amp = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_carrier_qualifier #(
        .SAMPLE_W(SW), .LEAK_SHIFT(3), .CLK_DIV(DIV), .ACQ_BITS(ACQ),
        .REL_BITS(REL), .PRE_MIN(PMIN), .MARK_MIN(MMIN)
    ) i_fsk_carrier_qualifier (
        .clk(clk), .rst(rst), .en(en), .sample_in(sample_in),
        .level_thresh(level_thresh), .raw_bit(raw_bit),
        .carrier_n(carrier_n), .cooked_data(cooked_data)
    );

    // tone: constant magnitude, alternating sign every clock
    initial begin
        bit s = 1'b0;
        forever begin
            @(negedge clk);
            s = ~s;
            sample_in = s ? SW'(amp) : SW'(-amp);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected cooked value for bit k of a valid frame with preamble length p
    function automatic bit exp_cooked(input int k, input int p, input bit b);
        return (k >= p + MMIN - 2) ? b : 1'b1;
    endfunction

    // one bit period aligned to the tick rate; returns cooked at end of the period
    task automatic send_bit(input bit b, output bit cooked);
        raw_bit = b;
        wait_clks(DIV);
        cooked = cooked_data;
    endtask

    task automatic acquire(input int a);
        amp = a;
        wait_clks((ACQ + 1) * DIV + 80);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
        end
    end

    initial begin
        bit c;
        bit data [24];
        void'($urandom(32'd20240611));

        // R1: reset state
        wait_clks(4);
        check(carrier_n == 1'b1, "R1 reset carrier_n", carrier_n, 1);
        check(cooked_data == 1'b1, "R1 reset cooked", cooked_data, 1);
        rst = 1'b0;
        en  = 1'b1;
        wait_clks(3);

        // R3, R6: acquisition window
        amp = 1000;
        wait_clks((ACQ - 1) * DIV - 2);
        check(carrier_n == 1'b1, "R3 not before window", carrier_n, 1);
        wait_clks(2 * DIV + 82);
        check(carrier_n == 1'b0, "R3 asserted after window", carrier_n, 0);
        check(cooked_data == 1'b1, "R7 idle marks without preamble", cooked_data, 1);

        // R5: short dropout tolerated
        amp = 0;
        wait_clks((REL - 3) * DIV);
        check(carrier_n == 1'b0, "R5 during dropout", carrier_n, 0);
        amp = 1000;
        wait_clks(40);
        check(carrier_n == 1'b0, "R5 after dropout", carrier_n, 0);
        amp = 0;
        wait_clks((REL - 3) * DIV);
        amp = 1000;
        wait_clks(8);
        check(carrier_n == 1'b0, "R5 release count restarted", carrier_n, 0);

        // R9: short preamble never passes
        for (int k = 0; k < 6; k++) begin
            send_bit(k[0], c);
            check(c == 1'b1, "R9 short preamble", c, 1);
        end
        for (int k = 0; k < 8; k++) begin
            send_bit(1'b1, c);
            check(c == 1'b1, "R9 marks after short preamble", c, 1);
        end

        // R10: mark run broken by a space
        for (int k = 0; k < 12; k++) send_bit(k[0], c);
        send_bit(1'b1, c);
        send_bit(1'b0, c);
        check(c == 1'b1, "R10 broken mark run", c, 1);
        for (int k = 0; k < 8; k++) begin
            send_bit(1'b1, c);
            check(c == 1'b1, "R10 no pass after break", c, 1);
        end

        // R7, R8, R6: valid frame with random message
        for (int k = 0; k < 24; k++) data[k] = 1'($urandom_range(0, 1));
        for (int k = 0; k < 12 + 6 + 24; k++) begin
            bit b;
            if (k < 12)          b = k[0];
            else if (k < 18)     b = 1'b1;
            else                 b = data[k - 18];
            send_bit(b, c);
            check(c == exp_cooked(k, 12, b), "R7 R8 cooked stream", c, exp_cooked(k, 12, b));
        end

        // R4, R8: release
        raw_bit = 1'b0;
        amp = 0;
        wait_clks(20);
        check(cooked_data == 1'b0, "R8 follows raw while qualified", cooked_data, 0);
        wait_clks((REL - 1) * DIV - 22);
        check(carrier_n == 1'b0, "R4 not before window", carrier_n, 0);
        wait_clks(2 * DIV + 42);
        check(carrier_n == 1'b1, "R4 released after window", carrier_n, 1);
        check(cooked_data == 1'b1, "R8 idle after release", cooked_data, 1);

        // R8: re-acquire, no preamble, no data
        raw_bit = 1'b1;
        acquire(1000);
        check(carrier_n == 1'b0, "R3 re-acquire", carrier_n, 0);
        for (int k = 0; k < 16; k++) begin
            bit b;
            b = (k % 4) < 2;
            send_bit(b, c);
            check(c == 1'b1, "R8 validator reset after release", c, 1);
        end

        // R1: disable while qualified
        raw_bit = 1'b0;
        en = 1'b0;
        #1;
        check(cooked_data == 1'b1, "R1 cooked idle when disabled", cooked_data, 1);
        wait_clks(1);
        check(carrier_n == 1'b1, "R1 carrier idle when disabled", carrier_n, 1);
        en = 1'b1;
        raw_bit = 1'b1;
        amp = 0;
        wait_clks(40);

        // R2: threshold is strict
        amp = THR;
        wait_clks((ACQ + 4) * DIV + 150);
        check(carrier_n == 1'b1, "R2 level equal to threshold", carrier_n, 1);
        amp = THR + 20;
        wait_clks((ACQ + 1) * DIV + 120);
        check(carrier_n == 1'b0, "R2 level above threshold", carrier_n, 0);
        amp = 0;
        wait_clks((REL + 1) * DIV + 40);

        // R2, R3, R4: random amplitudes
        for (int i = 0; i < 4; i++) begin
            acquire($urandom_range(THR + 60, 2000));
            check(carrier_n == 1'b0, "R3 random strong level", carrier_n, 0);
            amp = $urandom_range(0, THR - 100);
            wait_clks((REL + 1) * DIV + 40);
            check(carrier_n == 1'b1, "R4 random weak level", carrier_n, 1);
        end

        done = 1'b1;
        report();
    end
endmodule